// File: doc/BRIEF.md
# Multigrid V-Cycle Sequencer

This block is the control engine for a geometric multigrid solver of a 2D Poisson problem on a square mesh. The mesh side halves from one level to the next coarser one. The block holds no grid data and does no arithmetic. For each phase of a V-cycle it sends a one-cycle command pulse to an external operator engine, together with the level index that engine should work on. It then waits for that engine's done pulse before it moves on. The six engines are smoothing, residual, restriction, coarse solve, correction clearing plus prolongation, and correction.

The recursion of the textbook method becomes an explicit level counter. On the way down, each level is smoothed, its residual is formed, and the residual is restricted to the next coarser level. The coarsest level gets a single solve. On the way up, at each finer level the correction array is zeroed, the coarse correction is prolongated into it, the correction is applied, and the level is smoothed again. After the finest level is post-smoothed, a residual metric supplied from outside is compared with a tolerance. The block then either finishes or starts another V-cycle. A cycle limit ends a solve that does not converge and flags it.

Top module: `mg_vcycle_seq`

## Requirements
- R1: Reset state. After reset, `busy_o`, `done_o`, `not_conv_o` and `op_go_o` are all 0 and `cycles_o` is 0. A `start_i` pulse while idle begins a solve with a smoothing command at level 0, the finest level.
- R2: Command encoding. `op_go_o` bit positions are: 0 smooth, 1 residual, 2 restrict, 3 coarse solve, 4 clear correction, 5 prolongate, 6 correct. Each command is a one-cycle pulse, at most one bit is high at a time, and `op_level_o` carries the target level while the pulse is high.
- R3: Descent. At each level L from 0 to NLEV-1, the block issues PRE_SWEEPS (default 2) smooth commands, then residual, then restrict, all at level L. It then moves to level L+1. NLEV is FINE_LOG2 minus COARSE_LOG2.
- R4: At the coarsest level (index NLEV), exactly one coarse-solve command is issued, with no smoothing and no restriction at that level.
- R5: Ascent. For each level L from NLEV-1 down to 0, the block issues clear, prolongate, correct, then POST_SWEEPS (default 2) smooth commands, all at level L. The clear always comes before the prolongation at the same level.
- R6: After each command the block issues nothing further until the done bit at the same position in `op_done_i` is 1. Done bits that arrive while idle, or that belong to a different command, are ignored.
- R7: Once level 0 has been post-smoothed, `cycles_o` increments by one and `metric_i` is sampled. If the metric is strictly below TOL (unsigned), `done_o` pulses for one cycle, `busy_o` falls and `not_conv_o` is 0. Otherwise a new V-cycle begins at level 0.
- R8: If `cycles_o` reaches MAX_CYCLES without convergence, the solve stops with a `done_o` pulse and `not_conv_o` = 1. Both values hold until the next start.
- R9: A new start clears `cycles_o` and `not_conv_o` to 0.
- R10: `start_i` while busy has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a solve (sampled only when idle) |
| op_done_i | input | 7 | Done pulses from engines, same bit order as op_go_o |
| metric_i | input | MW | Residual measure, unsigned fixed point |
| op_go_o | output | 7 | One-hot command pulses |
| op_level_o | output | LVL_W | Level index for the current command, 0 = finest |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle pulse when a solve ends |
| cycles_o | output | CW | V-cycles completed in this solve |
| not_conv_o | output | 1 | Solve ended at the cycle limit |

## Verification
The command stream is tried under four metric patterns. A metric below tolerance on the first cycle shows a single complete descent and ascent. A metric that falls below tolerance on the third cycle shows that restarts begin again at level 0. A metric held at or above tolerance, including a value exactly equal to it, shows the cycle limit and the strict comparison. A zero metric after a failed solve shows that the counters are cleared. Engine response delays vary from command to command, and stray done bits are injected while idle and during a wait; these separate a block that truly waits for the matching bit from one that runs on a fixed schedule.

// File: rtl/mg_seq_pkg.sv
package mg_seq_pkg;

    localparam int unsigned NUM_OPS = 7;

    // bit position in the command vector equals the enum value
    typedef enum logic [2:0] {
        OP_SMOOTH   = 3'd0,
        OP_RESID    = 3'd1,
        OP_RESTRICT = 3'd2,
        OP_CSOLVE   = 3'd3,
        OP_CLEAR    = 3'd4,
        OP_PROLONG  = 3'd5,
        OP_CORRECT  = 3'd6
    } mg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_EVAL
    } mg_st_e;

endpackage

// File: rtl/mg_seq_step.sv
module mg_seq_step
    import mg_seq_pkg::*;
#(
    parameter int unsigned NLEV        = 3,
    parameter int unsigned PRE_SWEEPS  = 2,
    parameter int unsigned POST_SWEEPS = 2,
    parameter int unsigned LVL_W       = 2,
    parameter int unsigned SW_W        = 2
) (
    input  mg_op_e             op_i,
    input  logic [LVL_W-1:0]   lev_i,
    input  logic               up_i,
    input  logic [SW_W-1:0]    sweep_i,
    output mg_op_e             op_o,
    output logic [LVL_W-1:0]   lev_o,
    output logic               up_o,
    output logic [SW_W-1:0]    sweep_o,
    output logic               last_o
);

    localparam logic [SW_W-1:0]  PRE_LAST  = SW_W'(PRE_SWEEPS - 1);
    localparam logic [SW_W-1:0]  POST_LAST = SW_W'(POST_SWEEPS - 1);
    localparam logic [LVL_W-1:0] COARSEST  = LVL_W'(NLEV);

    logic [LVL_W-1:0] lev_dn;
    logic [LVL_W-1:0] lev_up;

    assign lev_dn = lev_i + LVL_W'(1);
    assign lev_up = lev_i - LVL_W'(1);

    always_comb begin
        op_o    = op_i;
        lev_o   = lev_i;
        up_o    = up_i;
        sweep_o = '0;
        last_o  = 1'b0;
        unique case (op_i)
            OP_SMOOTH: begin
                if (up_i) begin
                    if (sweep_i < POST_LAST) begin
                        sweep_o = sweep_i + SW_W'(1);
                    end else if (lev_i == '0) begin
                        last_o = 1'b1;
                    end else begin
                        lev_o = lev_up;
                        op_o  = OP_CLEAR;
                    end
                end else begin
                    if (sweep_i < PRE_LAST) begin
                        sweep_o = sweep_i + SW_W'(1);
                    end else begin
                        op_o = OP_RESID;
                    end
                end
            end
            OP_RESID:    op_o = OP_RESTRICT;
            OP_RESTRICT: begin
                lev_o = lev_dn;
                op_o  = (lev_dn == COARSEST) ? OP_CSOLVE : OP_SMOOTH;
            end
            OP_CSOLVE: begin
                lev_o = lev_up;
                up_o  = 1'b1;
                op_o  = OP_CLEAR;
            end
            OP_CLEAR:   op_o = OP_PROLONG;
            OP_PROLONG: op_o = OP_CORRECT;
            OP_CORRECT: op_o = OP_SMOOTH;
            default:    op_o = OP_SMOOTH;
        endcase
    end

endmodule

// File: rtl/mg_seq_conv.sv
module mg_seq_conv #(
    parameter int unsigned MW         = 24,
    parameter int unsigned TOL        = 66,
    parameter int unsigned CW         = 3,
    parameter int unsigned MAX_CYCLES = 4
) (
    input  logic [MW-1:0] metric_i,
    input  logic [CW-1:0] cyc_i,
    output logic          conv_o,
    output logic          limit_o
);

    localparam logic [MW-1:0] TOL_V = MW'(TOL);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_CYCLES);

    assign conv_o  = metric_i < TOL_V;
    assign limit_o = cyc_i >= MAX_V;

endmodule

// File: rtl/mg_seq_cmd.sv
module mg_seq_cmd
    import mg_seq_pkg::*;
(
    input  mg_op_e              op_i,
    input  logic                issue_i,
    output logic [NUM_OPS-1:0]  sel_o,
    output logic [NUM_OPS-1:0]  go_o
);

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_dec
        assign sel_o[k] = (op_i == mg_op_e'(3'(k)));
        assign go_o[k]  = issue_i & sel_o[k];
    end

endmodule

// File: rtl/mg_vcycle_seq.sv
module mg_vcycle_seq
    import mg_seq_pkg::*;
#(
    parameter int unsigned FINE_LOG2   = 4,
    parameter int unsigned COARSE_LOG2 = 1,
    parameter int unsigned PRE_SWEEPS  = 2,
    parameter int unsigned POST_SWEEPS = 2,
    parameter int unsigned MAX_CYCLES  = 4,
    parameter int unsigned MW          = 24,
    parameter int unsigned TOL         = 66,
    localparam int unsigned NLEV       = FINE_LOG2 - COARSE_LOG2,
    localparam int unsigned LVL_W      = $clog2(NLEV + 1),
    localparam int unsigned CW         = $clog2(MAX_CYCLES + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [NUM_OPS-1:0]   op_done_i,
    input  logic [MW-1:0]        metric_i,
    output logic [NUM_OPS-1:0]   op_go_o,
    output logic [LVL_W-1:0]     op_level_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [CW-1:0]        cycles_o,
    output logic                 not_conv_o
);

    localparam int unsigned SW_MAX = (PRE_SWEEPS > POST_SWEEPS) ? PRE_SWEEPS : POST_SWEEPS;
    localparam int unsigned SW_W   = $clog2(SW_MAX + 1);

    typedef struct packed {
        mg_st_e           st;
        mg_op_e           op;
        logic [LVL_W-1:0] lev;
        logic             up;
        logic [SW_W-1:0]  sweep;
        logic [CW-1:0]    cyc;
        logic             nconv;
        logic             fin;
    } seq_s;

    localparam seq_s SEQ_RST = '{st: ST_IDLE, op: OP_SMOOTH, lev: '0, up: 1'b0,
                                 sweep: '0, cyc: '0, nconv: 1'b0, fin: 1'b0};

    seq_s seq_d, seq_q;

    mg_op_e               nx_op;
    logic [LVL_W-1:0]     nx_lev;
    logic                 nx_up;
    logic [SW_W-1:0]      nx_sweep;
    logic                 nx_last;
    logic [CW-1:0]        cyc_inc;
    logic                 is_conv;
    logic                 at_limit;
    logic [NUM_OPS-1:0]   op_sel;
    logic                 done_hit;

    mg_seq_step #(
        .NLEV        (NLEV),
        .PRE_SWEEPS  (PRE_SWEEPS),
        .POST_SWEEPS (POST_SWEEPS),
        .LVL_W       (LVL_W),
        .SW_W        (SW_W)
    ) i_step (
        .op_i    (seq_q.op),
        .lev_i   (seq_q.lev),
        .up_i    (seq_q.up),
        .sweep_i (seq_q.sweep),
        .op_o    (nx_op),
        .lev_o   (nx_lev),
        .up_o    (nx_up),
        .sweep_o (nx_sweep),
        .last_o  (nx_last)
    );

    assign cyc_inc = seq_q.cyc + CW'(1);

    mg_seq_conv #(
        .MW         (MW),
        .TOL        (TOL),
        .CW         (CW),
        .MAX_CYCLES (MAX_CYCLES)
    ) i_conv (
        .metric_i (metric_i),
        .cyc_i    (cyc_inc),
        .conv_o   (is_conv),
        .limit_o  (at_limit)
    );

    mg_seq_cmd i_cmd (
        .op_i    (seq_q.op),
        .issue_i (seq_q.st == ST_ISSUE),
        .sel_o   (op_sel),
        .go_o    (op_go_o)
    );

    assign done_hit = |(op_done_i & op_sel);

    always_comb begin
        seq_d     = seq_q;
        seq_d.fin = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_ISSUE;
                    seq_d.op    = OP_SMOOTH;
                    seq_d.lev   = '0;
                    seq_d.up    = 1'b0;
                    seq_d.sweep = '0;
                    seq_d.cyc   = '0;
                    seq_d.nconv = 1'b0;
                end
            end
            ST_ISSUE: seq_d.st = ST_WAIT;
            ST_WAIT: begin
                if (done_hit) begin
                    if (nx_last) begin
                        seq_d.st = ST_EVAL;
                    end else begin
                        seq_d.st    = ST_ISSUE;
                        seq_d.op    = nx_op;
                        seq_d.lev   = nx_lev;
                        seq_d.up    = nx_up;
                        seq_d.sweep = nx_sweep;
                    end
                end
            end
            ST_EVAL: begin
                seq_d.cyc = cyc_inc;
                if (is_conv || at_limit) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.fin   = 1'b1;
                    seq_d.nconv = !is_conv;
                end else begin
                    seq_d.st    = ST_ISSUE;
                    seq_d.op    = OP_SMOOTH;
                    seq_d.lev   = '0;
                    seq_d.up    = 1'b0;
                    seq_d.sweep = '0;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_level_o = seq_q.lev;
    assign busy_o     = seq_q.st != ST_IDLE;
    assign done_o     = seq_q.fin;
    assign cycles_o   = seq_q.cyc;
    assign not_conv_o = seq_q.nconv;

    // R2: never more than one command at a time
    a_r2_go_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(op_go_o));

    // R2: commands are single-cycle pulses
    a_r2_go_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_go_o != '0) |=> (op_go_o == '0));

    // R4: coarse solve only on the coarsest level
    a_r4_csolve_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_go_o[3] |-> (op_level_o == LVL_W'(NLEV)));

    // R3: restriction never issued from the coarsest level
    a_r3_restrict_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_go_o[2] |-> (op_level_o < LVL_W'(NLEV)));

    // R7: cycle count only steps up by one or returns to zero
    a_r7_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cycles_o != $past(cycles_o)) |-> ((cycles_o == $past(cycles_o) + CW'(1)) || (cycles_o == '0)));

    // R7: a finishing pulse leaves the block idle
    a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: the flag only appears at the cycle limit
    a_r8_nconv_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        not_conv_o |-> (cycles_o == CW'(MAX_CYCLES)));

endmodule

// File: tb/test_mg_vcycle_seq.sv
module test_mg_vcycle_seq;

    localparam int NL    = 3;
    localparam int PRE   = 2;
    localparam int POST  = 2;
    localparam int MAXC  = 4;
    localparam int TOLV  = 66;
    localparam int ITEMS = NL * (PRE + 2) + 1 + NL * (3 + POST);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  rsp_done = '0;
    logic [6:0]  spur_done = '0;
    logic [6:0]  op_done;
    logic [23:0] metric = '0;
    logic [6:0]  op_go;
    logic [1:0]  op_level;
    logic        busy, done, not_conv;
    logic [2:0]  cycles;

    assign op_done = rsp_done | spur_done;

    always #2 clk = ~clk;

    mg_vcycle_seq i_mg_vcycle_seq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .op_done_i  (op_done),
        .metric_i   (metric),
        .op_go_o    (op_go),
        .op_level_o (op_level),
        .busy_o     (busy),
        .done_o     (done),
        .cycles_o   (cycles),
        .not_conv_o (not_conv)
    );

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int plan[8];
    int pos_in_cyc = 0;
    int cyc_idx = 0;
    int pend_op = 0;
    int pend_cnt = 0;
    int rsp_seed = 0;
    bit hold_rsp = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // driver: expected command stream of one V-cycle (R3, R4, R5)
    task automatic push_cycle();
        for (int l = 0; l < NL; l++) begin
            for (int s = 0; s < PRE; s++) exp_q.push_back(0 * 16 + l);
            exp_q.push_back(1 * 16 + l);
            exp_q.push_back(2 * 16 + l);
        end
        exp_q.push_back(3 * 16 + NL);
        for (int l = NL - 1; l >= 0; l--) begin
            exp_q.push_back(4 * 16 + l);
            exp_q.push_back(5 * 16 + l);
            exp_q.push_back(6 * 16 + l);
            for (int s = 0; s < POST; s++) exp_q.push_back(0 * 16 + l);
        end
    endtask

    // monitor + responder
    always @(negedge clk) begin
        rsp_done = '0;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) rsp_done = 7'(1 << pend_op);
        end
        if (rst_n && op_go != '0) begin
            int idx;
            int act;
            idx = 0;
            for (int k = 0; k < 7; k++) if (op_go[k]) idx = k;
            act = idx * 16 + int'(op_level);
            if (pos_in_cyc == 0) metric = 24'(plan[cyc_idx]);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R4/R5 unexpected command", act, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(act == e, "R3/R4/R5 command op*16+level", act, e);
            end
            pos_in_cyc++;
            if (pos_in_cyc == ITEMS) begin
                pos_in_cyc = 0;
                cyc_idx++;
            end
            if (!hold_rsp) begin
                pend_op  = idx;
                pend_cnt = 1 + (rsp_seed % 4);
                rsp_seed++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int exp_cyc, input bit exp_nc, input bit poke_start);
        int n;
        n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (poke_start && n == 40) begin
                start = 1'b1;      // R10: start while busy
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk(cycles == 3'(exp_cyc), "R7 cycles at finish", int'(cycles), exp_cyc);
        chk(not_conv == exp_nc, "R8 not_conv at finish", int'(not_conv), int'(exp_nc));
        chk(exp_q.size() == 0, "R3/R4/R5 all commands seen", exp_q.size(), 0);
        chk(!busy, "R7 idle with done", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R7 done is one pulse", int'(done), 0);
        chk(cycles == 3'(exp_cyc), "R8 cycles held", int'(cycles), exp_cyc);
        chk(not_conv == exp_nc, "R8 flag held", int'(not_conv), int'(exp_nc));
        repeat (3) @(negedge clk);
        chk(op_go == '0, "R6 no command after finish", int'(op_go), 0);
    endtask

    task automatic prep(input int ncyc);
        pos_in_cyc = 0;
        cyc_idx = 0;
        for (int c = 0; c < ncyc; c++) push_cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(!done, "R1 done after reset", int'(done), 0);
        chk(cycles == 0, "R1 cycles after reset", int'(cycles), 0);
        chk(!not_conv, "R1 not_conv after reset", int'(not_conv), 0);
        chk(op_go == '0, "R1 no command after reset", int'(op_go), 0);

        // R6: done bits while idle are ignored
        spur_done = 7'h7f;
        repeat (2) @(negedge clk);
        spur_done = '0;
        @(negedge clk);
        chk(!busy, "R6 idle ignores done", int'(busy), 0);
        chk(op_go == '0, "R6 idle no command", int'(op_go), 0);

        // run A: converge in one cycle, with a stray done during a wait
        plan[0] = 10;
        prep(1);
        hold_rsp = 1'b1;
        pulse_start();
        while (op_go == '0) @(negedge clk);
        chk(op_level == 0, "R1 first command at level 0", int'(op_level), 0);
        chk(op_go == 7'b0000001, "R1 first command is smooth", int'(op_go), 1);
        @(negedge clk);
        spur_done = 7'b1111110;     // R6: wrong bits
        @(negedge clk);
        spur_done = '0;
        for (int k = 0; k < 3; k++) begin
            chk(op_go == '0, "R6 wrong done bit ignored", int'(op_go), 0);
            chk(busy, "R6 still waiting", int'(busy), 1);
            @(negedge clk);
        end
        hold_rsp = 1'b0;
        spur_done = 7'b0000001;
        @(negedge clk);
        spur_done = '0;
        wait_end(1, 1'b0, 1'b0);

        // run B: metric drops below tolerance on the third cycle, start poked while busy
        plan[0] = 500; plan[1] = TOLV; plan[2] = TOLV - 1;
        prep(3);
        pulse_start();
        wait_end(3, 1'b0, 1'b1);

        // run C: never converges -> cycle limit
        plan[0] = TOLV; plan[1] = 70000; plan[2] = TOLV; plan[3] = TOLV;
        prep(MAXC);
        pulse_start();
        wait_end(MAXC, 1'b1, 1'b0);

        // run D: restart clears counters (R9)
        plan[0] = 0;
        prep(1);
        pulse_start();
        chk(cycles == 0, "R9 cycles cleared on start", int'(cycles), 0);
        chk(!not_conv, "R9 not_conv cleared on start", int'(not_conv), 0);
        wait_end(1, 1'b0, 1'b0);

        wrap_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        wrap_up();
    end

endmodule